// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block steps a microprogrammed control unit through its control store. It keeps the current control-store address in a control address register (CAR) and a one-deep return register (SBR). A small read-only control store is built in. Every cycle, the block looks up the microword at CAR and drives the microword's control field straight onto the datapath. The microword's sequencing fields then pick the address for the next cycle.

There are four ways to form the next address: step to CAR+1, branch to the microword's target when a selected condition is true, map the machine opcode to the start of its routine, or return through the SBR. A call branches the same way and also saves CAR+1 in the SBR. The surrounding logic supplies the opcode and the datapath status flags, and it deasserts reset synchronously to the clock.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_n is low, car is 0 and the return register is 0, asynchronously; ctrl_word is then 0x01.
- R2: ctrl_word always equals the control field of the microword at the current car, in the same cycle.
- R3: A microword of type 00 (conditional jump) whose selected condition is false loads car with car+1, modulo 128.
- R4: A type 00 microword whose selected condition is true loads car with the microword's target address.
- R5: A type 01 microword (conditional call) with a true condition loads car with the target and the return register with car+1. With a false condition it loads car with car+1 and leaves the return register unchanged.
- R6: A type 10 microword (return) loads car from the return register, whatever the status inputs are.
- R7: A type 11 microword (map) loads car with {0, opcode, 00}, so opcode k starts at address 4k. The status inputs do not affect it.
- R8: The 2-bit condition select means constant true for 0, and status[k-1] for k = 1 to 3.
- R9: The control store holds the following program; any word not listed is control 0x00 with an unconditional jump to 0.
  - Address 0 holds control 0x01 and is a map word.
  - For opcode n from 1 to 15, with base b = 4n:
    - b holds control {n,0x1}, jump, select n[1:0], target b+2.
    - b+1 holds control {n,0x2}, call, select n[3:2], target 64.
    - b+2 holds control {n,0x4}, unconditional jump to 0.
  - Address 64 holds control 0x80, jump, select 1, target 66.
  - Addresses 65 and 66 hold controls 0x81 and 0x82, and both are returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Machine opcode used by map words |
| status | input | 3 | Datapath condition flags |
| ctrl_word | output | 8 | Control field of the current microword |
| car | output | 7 | Current control-store address |

## Verification
The sequencer runs under four kinds of status input. With all flags held low, every conditional word falls through, which separates in-line stepping from branching and shows that skipped calls leave the return register alone. With all flags high, every branch and call is taken, which tests target loading and the saving and use of the return address. The third pattern walks the opcode through all sixteen values so that every routine base is reached by mapping. Pseudo-random flags and opcodes, with a reset in the middle of the run, then mix taken and untaken paths inside the subroutine and check that every flag is selected.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    BT_JMP  = 2'b00,
    BT_CALL = 2'b01,
    BT_RET  = 2'b10,
    BT_MAP  = 2'b11
  } btype_e;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW  = 7,
  parameter int CWW = 8,
  parameter int OPW = 4,
  parameter int CSW = 2
) (
  input  logic [AW-1:0]  addr,
  output logic [CWW-1:0] cw,
  output logic [CSW-1:0] csel,
  output btype_e         btype,
  output logic [AW-1:0]  badr
);
  localparam int SUB_BASE = 1 << (AW - 1);
  localparam int ROUT_END = 1 << (OPW + 2);

  logic [OPW-1:0] op_n;
  logic [1:0]     off;

  assign op_n = addr[OPW+1:2];
  assign off  = addr[1:0];

  always_comb begin
    cw    = '0;
    csel  = '0;
    btype = BT_JMP;
    badr  = '0;
    if (addr == '0) begin
      cw    = CWW'(8'h01);
      btype = BT_MAP;
    end else if ((int'(addr) < ROUT_END) && (op_n != '0)) begin
      case (off)
        2'd0: begin
          cw    = CWW'({op_n, 4'h1});
          csel  = op_n[CSW-1:0];
          btype = BT_JMP;
          badr  = addr | AW'(2);
        end
        2'd1: begin
          cw    = CWW'({op_n, 4'h2});
          csel  = op_n[OPW-1 -: CSW];
          btype = BT_CALL;
          badr  = AW'(SUB_BASE);
        end
        2'd2: begin
          cw    = CWW'({op_n, 4'h4});
        end
        default: ;
      endcase
    end else if (int'(addr) == SUB_BASE) begin
      cw    = CWW'(8'h80);
      csel  = CSW'(1);
      btype = BT_JMP;
      badr  = AW'(SUB_BASE + 2);
    end else if (int'(addr) == SUB_BASE + 1) begin
      cw    = CWW'(8'h81);
      btype = BT_RET;
    end else if (int'(addr) == SUB_BASE + 2) begin
      cw    = CWW'(8'h82);
      btype = BT_RET;
    end
  end
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
  parameter int NST = 3,
  parameter int CSW = 2
) (
  input  logic [NST-1:0] status,
  input  logic [CSW-1:0] csel,
  output logic           cond
);
  localparam int NSRC = 1 << CSW;

  logic [NSRC-1:0] src;

  assign src[0] = 1'b1;
  for (genvar g = 1; g < NSRC; g++) begin : g_src
    if (g <= NST) begin : g_live
      assign src[g] = status[g-1];
    end else begin : g_tie
      assign src[g] = 1'b0;
    end
  end

  assign cond = src[csel];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW  = 7,
  parameter int OPW = 4
) (
  input  logic [AW-1:0]  car_q,
  input  logic [AW-1:0]  sbr_q,
  input  btype_e         btype,
  input  logic [AW-1:0]  badr,
  input  logic           cond,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  car_d,
  output logic [AW-1:0]  sbr_d,
  output logic           sbr_en
);
  localparam int PADW = AW - OPW - 2;

  logic [AW-1:0] car_inc;
  logic [AW-1:0] map_adr;

  assign car_inc = car_q + AW'(1);
  assign map_adr = {{PADW{1'b0}}, opcode, 2'b00};

  always_comb begin
    car_d  = car_inc;
    sbr_d  = car_inc;
    sbr_en = 1'b0;
    unique case (btype)
      BT_JMP:  if (cond) car_d = badr;
      BT_CALL: if (cond) begin
                 car_d  = badr;
                 sbr_en = 1'b1;
               end
      BT_RET:  car_d = sbr_q;
      BT_MAP:  car_d = map_adr;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW  = 7,
  parameter int CWW = 8,
  parameter int OPW = 4,
  parameter int NST = 3,
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic [NST-1:0] status,
  output logic [CWW-1:0] ctrl_word,
  output logic [AW-1:0]  car
);
  logic [AW-1:0]  car_q, car_d;
  logic [AW-1:0]  sbr_q, sbr_d;
  logic           sbr_en;
  logic [CSW-1:0] csel;
  btype_e         btype;
  logic [AW-1:0]  badr;
  logic           cond;

  useq_rom #(.AW(AW), .CWW(CWW), .OPW(OPW), .CSW(CSW)) u_rom (
    .addr  (car_q),
    .cw    (ctrl_word),
    .csel  (csel),
    .btype (btype),
    .badr  (badr)
  );

  useq_cond_sel #(.NST(NST), .CSW(CSW)) u_cond (
    .status (status),
    .csel   (csel),
    .cond   (cond)
  );

  useq_next #(.AW(AW), .OPW(OPW)) u_next (
    .car_q  (car_q),
    .sbr_q  (sbr_q),
    .btype  (btype),
    .badr   (badr),
    .cond   (cond),
    .opcode (opcode),
    .car_d  (car_d),
    .sbr_d  (sbr_d),
    .sbr_en (sbr_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= '0;
    else        car_q <= car_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sbr_q <= '0;
    else if (sbr_en) sbr_q <= sbr_d;
  end

  assign car = car_q;

  // R3: untaken jump steps by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (btype == BT_JMP && !cond) |=> car_q == $past(car_q) + AW'(1));

  // R4: taken jump goes to target
  a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (btype == BT_JMP && cond) |=> car_q == $past(badr));

  // R5: taken call saves the return point
  a_r5_call_save: assert property (@(posedge clk) disable iff (!rst_n)
    (btype == BT_CALL && cond) |=> (sbr_q == $past(car_q) + AW'(1)) && (car_q == $past(badr)));

  // R5: return register holds unless a call is taken
  a_r5_sbr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(btype == BT_CALL && cond) |=> $stable(sbr_q));

  // R6: return reloads from the return register
  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (btype == BT_RET) |=> car_q == $past(sbr_q));

  // R7: map goes to the opcode routine base
  a_r7_map: assert property (@(posedge clk) disable iff (!rst_n)
    (btype == BT_MAP) |=> car_q == AW'({$past(opcode), 2'b00}));

  // R8: select 0 is always true
  a_r8_const_true: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == '0) |-> cond);
endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode = 4'd0;
  logic [2:0] status = 3'd0;
  logic [7:0] ctrl_word;
  logic [6:0] car;

  int n_cmp = 0;
  int n_bad = 0;
  int car_m = 0;
  int sbr_m = 0;
  string tag_m = "R1";
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  useq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .status(status),
    .ctrl_word(ctrl_word), .car(car)
  );

  always #10 clk = ~clk;

  // program of R9, written from the requirement
  task automatic prog(input int a, output int cw, output int cs,
                      output int bt, output int ta);
    int n, o;
    n = a / 4; o = a % 4;
    cw = 0; cs = 0; bt = 0; ta = 0;
    if (a == 0) begin cw = 1; bt = 3; end
    else if (a == 64) begin cw = 8'h80; cs = 1; ta = 66; end
    else if (a == 65) begin cw = 8'h81; bt = 2; end
    else if (a == 66) begin cw = 8'h82; bt = 2; end
    else if (a < 64 && n > 0) begin
      if (o == 0) begin cw = n * 16 + 1; cs = n % 4; ta = a + 2; end
      else if (o == 1) begin cw = n * 16 + 2; cs = n / 4; bt = 1; ta = 64; end
      else if (o == 2) begin cw = n * 16 + 4; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_m = 0; sbr_m = 0; tag_m = "R1";
    end else begin
      int cw, cs, bt, ta;
      bit c;
      prog(car_m, cw, cs, bt, ta);
      c = (cs == 0) ? 1'b1 : status[cs-1];
      case (bt)
        0: begin
          if (c) begin car_m = ta; tag_m = "R4 R8"; end
          else begin car_m = (car_m + 1) % 128; tag_m = "R3 R8"; end
        end
        1: begin
          if (c) begin sbr_m = (car_m + 1) % 128; car_m = ta; end
          else car_m = (car_m + 1) % 128;
          tag_m = "R5";
        end
        2: begin car_m = sbr_m; tag_m = "R6"; end
        default: begin car_m = opcode * 4; tag_m = "R7"; end
      endcase
    end
  end

  task automatic check();
    int cw, cs, bt, ta;
    prog(car_m, cw, cs, bt, ta);
    n_cmp++;
    if (int'(car) != car_m) begin
      n_bad++;
      $display("FAIL %s car actual=%0d expected=%0d", tag_m, car, car_m);
    end
    n_cmp++;
    if (int'(ctrl_word) != cw) begin
      n_bad++;
      $display("FAIL R2 R9 ctrl_word actual=%0h expected=%0h", ctrl_word, cw);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [2:0] st);
    @(negedge clk);
    check();
    opcode = op;
    status = st;
  endtask

  task automatic run_rand(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0], lfsr[9:7]);
    end
  endtask

  initial begin
    // R1: reset state
    step(4'd0, 3'd0);
    step(4'd0, 3'd0);
    @(negedge clk) rst_n = 1'b1;
    // all flags low: fall-through paths
    for (int k = 0; k < 16; k++)
      for (int j = 0; j < 12; j++) step(4'(k), 3'b000);
    // all flags high: taken paths
    for (int k = 0; k < 16; k++)
      for (int j = 0; j < 12; j++) step(4'(k), 3'b111);
    run_rand(1500);
    // R1: reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    step(4'd5, 3'd7);
    step(4'd5, 3'd7);
    @(negedge clk) rst_n = 1'b1;
    run_rand(1500);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule